// File: doc/BRIEF.md
# Four-Channel Selectable-Source Engine Tick Divider

This block produces engine timing strobes for four serial-port channels, all inside one system clock domain. Three source strobes arrive as one-cycle pulses: a crystal tick and two PLL ticks, called path A and path B. Each channel takes one of them, divides it, and emits a one-cycle engine tick. Every channel is configured by its own 8-bit slice of a single 32-bit control word.

Inside a channel slice, the 2-bit select code picks the source. A 3-bit pre-scale value divides a PLL source before the main divide, and has no effect when the crystal is selected. A 3-bit main divide value sets the final ratio. One select code is reserved and silences the channel.

The control word sits at a single offset of a simple register bus. Software reads it back whole. Each channel is controlled by a small state machine with four states:
- `CH_DIRECT` (crystal, no pre-scale)
- `CH_PRE_A` (path A through the pre-scaler)
- `CH_PRE_B` (path B through the pre-scaler)
- `CH_HALT` (reserved code, silent)

The only transition is a register write that changes the channel's slice. That write moves the channel to the state named by the new select code, in the same cycle, and clears both of its counters.

Top module: `engtick_top`

## Requirements
- R1: The control word resets to zero. A write with `reg_addr` = 0x030 stores `reg_wdata` into the word. A read at 0x030 returns the whole word, and a read at any other address returns zero. A write to any other address leaves the word unchanged.
- R2: Channel k is configured by word bits [8k+7:8k]. Within a slice, bits [7:5] hold the main divide value N, bits [4:3] hold the select code S, and bits [2:0] hold the pre-scale value P.
- R3: With S = 00, the channel ticks on every (N+1)-th crystal strobe, and P has no effect.
- R4: With S = 10, the channel ticks on every (P+1)·(N+1)-th strobe of PLL path A.
- R5: With S = 11, the channel ticks on every (P+1)·(N+1)-th strobe of PLL path B.
- R6: With S = 01, the channel emits no ticks.
- R7: Each engine tick is one system clock wide and falls in the same cycle as the source strobe that completes the count.
- R8: A write that changes a channel's slice restarts that channel's count. Its first tick then comes on the R-th qualifying strobe after the write, where R is the ratio in R3–R5.
- R9: A write that leaves a channel's slice unchanged does not disturb that channel's phase.
- R10: Strobes from sources a channel has not selected have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_tick | input | 1 | Crystal source strobe, one cycle wide |
| pll_a_tick | input | 1 | PLL path A strobe, one cycle wide |
| pll_b_tick | input | 1 | PLL path B strobe, one cycle wide |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| eng_tick | output | 4 | Engine tick per channel, bit k for channel k |

## Verification
The three source strobes run at once, with periods of 3, 2 and 5 cycles. Their coincidences therefore show whether a channel counts only its own source, or leaks counts from the others.

The bench sweeps all 256 slice values. Each channel receives a different rotation of the same value, so every select code meets every pre-scale and main divide value on each channel position. These runs tell the crystal bypass apart from the pre-scaled PLL paths, and the two PLL paths apart from each other.

A final phase test rewrites the word with one channel's slice unchanged. It separates a per-channel restart from a global restart. Reads at the mapped offset and at a foreign offset, plus a write to the foreign offset, check the register decode.

// File: rtl/engtick_pkg.sv
package engtick_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [1:0] {
        CH_DIRECT = 2'd0,
        CH_HALT   = 2'd1,
        CH_PRE_A  = 2'd2,
        CH_PRE_B  = 2'd3
    } ch_state_t;

    function automatic ch_state_t state_for_sel(input logic [SEL_W-1:0] sel);
        ch_state_t st;
        unique case (sel)
            2'b00:   st = CH_DIRECT;
            2'b01:   st = CH_HALT;
            2'b10:   st = CH_PRE_A;
            default: st = CH_PRE_B;
        endcase
        return st;
    endfunction

endpackage

// File: rtl/engtick_div.sv
module engtick_div #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          hold,
    input  logic          in_tick,
    input  logic [CW-1:0] limit,
    output logic          out_tick
);

    logic [CW-1:0] cnt_q;
    logic          at_limit;

    assign at_limit = (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || hold) begin
            cnt_q <= '0;
        end else if (in_tick) begin
            cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
        end
    end

    assign out_tick = in_tick && at_limit && !hold;

endmodule

// File: rtl/engtick_chan.sv
module engtick_chan
    import engtick_pkg::*;
#(
    parameter int N_W = 3,
    parameter int P_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [SEL_W-1:0] new_sel,
    input  logic [N_W-1:0]   n_lim,
    input  logic [P_W-1:0]   p_lim,
    input  logic             xtal_tick,
    input  logic             pll_a_tick,
    input  logic             pll_b_tick,
    output logic             eng_tick
);

    ch_state_t state_q;
    ch_state_t state_d;

    logic pre_in;
    logic pre_hold;
    logic pre_out;
    logic fin_in;
    logic fin_hold;

    // next-state: only a slice-changing write moves the machine
    always_comb begin
        state_d = state_q;
        if (wr) begin
            state_d = state_for_sel(new_sel);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_DIRECT;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs: route strobes through the dividers per state
    always_comb begin
        pre_in   = 1'b0;
        pre_hold = 1'b1;
        fin_in   = 1'b0;
        fin_hold = 1'b1;
        unique case (state_q)
            CH_DIRECT: begin
                fin_in   = xtal_tick;
                fin_hold = 1'b0;
            end
            CH_PRE_A: begin
                pre_in   = pll_a_tick;
                pre_hold = 1'b0;
                fin_in   = pre_out;
                fin_hold = 1'b0;
            end
            CH_PRE_B: begin
                pre_in   = pll_b_tick;
                pre_hold = 1'b0;
                fin_in   = pre_out;
                fin_hold = 1'b0;
            end
            CH_HALT: begin
                pre_in   = 1'b0;
                fin_in   = 1'b0;
            end
        endcase
    end

    engtick_div #(.CW(P_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (wr),
        .hold     (pre_hold),
        .in_tick  (pre_in),
        .limit    (p_lim),
        .out_tick (pre_out)
    );

    engtick_div #(.CW(N_W)) u_fin (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (wr),
        .hold     (fin_hold),
        .in_tick  (fin_in),
        .limit    (n_lim),
        .out_tick (eng_tick)
    );

endmodule

// File: rtl/engtick_regs.sv
module engtick_regs #(
    parameter int              NUM_CH     = 4,
    parameter int              SLICE_W    = 8,
    parameter int              ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h030,
    localparam int             DATA_W     = NUM_CH * SLICE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [NUM_CH-1:0] slice_wr
);

    logic addr_hit;
    logic wr_hit;

    assign addr_hit = (reg_addr == REG_OFFSET);
    assign wr_hit   = reg_we && addr_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_word <= '0;
        end else if (wr_hit) begin
            ctrl_word <= reg_wdata;
        end
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_slice_wr
        assign slice_wr[k] = wr_hit &&
            (reg_wdata[k*SLICE_W +: SLICE_W] != ctrl_word[k*SLICE_W +: SLICE_W]);
    end

    assign reg_rdata = addr_hit ? ctrl_word : '0;

endmodule

// File: rtl/engtick_top.sv
module engtick_top
    import engtick_pkg::*;
#(
    parameter int                NUM_CH     = 4,
    parameter int                N_W        = 3,
    parameter int                P_W        = 3,
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h030,
    localparam int               SLICE_W    = N_W + SEL_W + P_W,
    localparam int               DATA_W     = NUM_CH * SLICE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xtal_tick,
    input  logic              pll_a_tick,
    input  logic              pll_b_tick,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] eng_tick
);

    logic [DATA_W-1:0] ctrl_word;
    logic [NUM_CH-1:0] slice_wr;

    engtick_regs #(
        .NUM_CH     (NUM_CH),
        .SLICE_W    (SLICE_W),
        .ADDR_W     (ADDR_W),
        .REG_OFFSET (REG_OFFSET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ctrl_word (ctrl_word),
        .slice_wr  (slice_wr)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
        logic [SLICE_W-1:0] cur_slice;
        logic [SLICE_W-1:0] new_slice;

        assign cur_slice = ctrl_word[k*SLICE_W +: SLICE_W];
        assign new_slice = reg_wdata[k*SLICE_W +: SLICE_W];

        engtick_chan #(.N_W(N_W), .P_W(P_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr         (slice_wr[k]),
            .new_sel    (new_slice[P_W +: SEL_W]),
            .n_lim      (cur_slice[SLICE_W-1 -: N_W]),
            .p_lim      (cur_slice[P_W-1:0]),
            .xtal_tick  (xtal_tick),
            .pll_a_tick (pll_a_tick),
            .pll_b_tick (pll_b_tick),
            .eng_tick   (eng_tick[k])
        );
    end

endmodule

// File: rtl/engtick_chk.sv
module engtick_chk #(
    parameter int                NUM_CH     = 4,
    parameter int                N_W        = 3,
    parameter int                P_W        = 3,
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h030,
    localparam int               SLICE_W    = N_W + 2 + P_W,
    localparam int               DATA_W     = NUM_CH * SLICE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xtal_tick,
    input logic              pll_a_tick,
    input logic              pll_b_tick,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [NUM_CH-1:0] eng_tick,
    input logic [DATA_W-1:0] ctrl_word
);

    // R1: a mapped write is visible on the next read at the offset
    a_r1_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == REG_OFFSET) ##1 (reg_addr == REG_OFFSET)
        |-> reg_rdata == $past(reg_wdata));

    // R1: the word only moves on a mapped write
    a_r1_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == REG_OFFSET) |=> $stable(ctrl_word));

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch_chk
        logic [SLICE_W-1:0] sl;
        logic [1:0]         sel;
        logic [N_W-1:0]     nv;
        logic [P_W-1:0]     pv;
        logic               src;

        assign sl  = ctrl_word[k*SLICE_W +: SLICE_W];
        assign sel = sl[P_W +: 2];
        assign nv  = sl[SLICE_W-1 -: N_W];
        assign pv  = sl[P_W-1:0];
        assign src = (sel == 2'b00) ? xtal_tick :
                     (sel == 2'b10) ? pll_a_tick :
                     (sel == 2'b11) ? pll_b_tick : 1'b0;

        // R6: reserved select is silent
        a_r6_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
            (sel == 2'b01) |-> !eng_tick[k]);

        // R7, R10: a tick needs a strobe from the selected source
        a_r10_tick_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
            eng_tick[k] |-> src);

        // R3: crystal with N=0 passes straight through
        a_r3_xtal_passthru: assert property (@(posedge clk) disable iff (!rst_n)
            (sel == 2'b00 && nv == '0) |-> (eng_tick[k] == xtal_tick));

        // R4: path A with unit ratios passes straight through
        a_r4_plla_passthru: assert property (@(posedge clk) disable iff (!rst_n)
            (sel == 2'b10 && nv == '0 && pv == '0) |-> (eng_tick[k] == pll_a_tick));

        // R5: path B with unit ratios passes straight through
        a_r5_pllb_passthru: assert property (@(posedge clk) disable iff (!rst_n)
            (sel == 2'b11 && nv == '0 && pv == '0) |-> (eng_tick[k] == pll_b_tick));
    end

endmodule

bind engtick_top engtick_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xtal_tick  (xtal_tick),
    .pll_a_tick (pll_a_tick),
    .pll_b_tick (pll_b_tick),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .eng_tick   (eng_tick),
    .ctrl_word  (ctrl_word)
);

// File: tb/sim_engtick_top.sv
module sim_engtick_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_tick = 1'b0;
    logic        pll_a_tick = 1'b0;
    logic        pll_b_tick = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = 12'h030;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  eng_tick;

    int   n_checks = 0;
    int   n_fails  = 0;
    int   cyc      = 0;
    bit   done     = 1'b0;

    logic [31:0] m_word = '0;
    int          m_cnt [4];
    bit          m_kept [4];

    always #5 clk = ~clk;

    engtick_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .xtal_tick  (xtal_tick),
        .pll_a_tick (pll_a_tick),
        .pll_b_tick (pll_b_tick),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .eng_tick   (eng_tick)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // R2 field layout used by the model: N=[7:5], S=[4:3], P=[2:0]
    task automatic compare_ticks();
        for (int k = 0; k < 4; k++) begin
            logic [7:0] sl;
            logic [1:0] s;
            int         ratio;
            bit         src;
            bit         exp;
            string      tag;
            sl    = m_word[k*8 +: 8];
            s     = sl[4:3];
            ratio = (s == 2'b00) ? (sl[7:5] + 1) : (sl[7:5] + 1) * (sl[2:0] + 1);
            src   = (s == 2'b00) ? xtal_tick : (s == 2'b10) ? pll_a_tick :
                    (s == 2'b11) ? pll_b_tick : 1'b0;
            if (src) m_cnt[k]++;
            exp = src && (m_cnt[k] % ratio == 0);
            unique case (s)
                2'b00: tag = "R3";
                2'b01: tag = "R6";
                2'b10: tag = "R4";
                default: tag = "R5";
            endcase
            tag = $sformatf("%s ch%0d R2 R7 R8 R10%s", tag, k, m_kept[k] ? " R9" : "");
            check(eng_tick[k] == exp, tag, 32'(eng_tick[k]), 32'(exp));
        end
    endtask

    // one cycle: optional write, strobes driven at the falling edge
    task automatic step(input bit wr, input logic [11:0] addr, input logic [31:0] wd);
        @(negedge clk);
        reg_we    = wr;
        reg_addr  = addr;
        reg_wdata = wd;
        if (wr) begin
            xtal_tick  = 1'b0;
            pll_a_tick = 1'b0;
            pll_b_tick = 1'b0;
        end else begin
            xtal_tick  = (cyc % 3 == 0);
            pll_a_tick = (cyc % 2 == 1);
            pll_b_tick = (cyc % 5 == 2);
        end
        #1;
        compare_ticks();
        if (wr && addr == 12'h030) begin
            for (int k = 0; k < 4; k++) begin
                m_kept[k] = (wd[k*8 +: 8] == m_word[k*8 +: 8]);
                if (!m_kept[k]) m_cnt[k] = 0;
            end
            m_word = wd;
        end
        cyc++;
    endtask

    task automatic read_check(input logic [11:0] addr, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_we     = 1'b0;
        reg_addr   = addr;
        xtal_tick  = 1'b0;
        pll_a_tick = 1'b0;
        pll_b_tick = 1'b0;
        #1;
        check(reg_rdata == exp, req, reg_rdata, exp);
        cyc++;
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin
            m_cnt[k]  = 0;
            m_kept[k] = 1'b0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state: word reads back zero, foreign address reads zero
        read_check(12'h030, 32'h0, "R1 reset word");
        read_check(12'h034, 32'h0, "R1 foreign read");

        // reset config: crystal, ratio 1
        for (int i = 0; i < 12; i++) step(1'b0, 12'h030, 32'h0);

        // sweep every slice value, rotated across channels
        for (int v = 0; v < 256; v++) begin
            logic [31:0] w;
            for (int k = 0; k < 4; k++) w[k*8 +: 8] = 8'(v + 67 * k);
            step(1'b1, 12'h030, w);
            read_check(12'h030, w, "R1 readback");
            for (int i = 0; i < 170; i++) step(1'b0, 12'h030, 32'h0);
        end

        // R1: a write to a foreign offset is ignored
        step(1'b1, 12'h034, 32'hFFFF_FFFF);
        read_check(12'h030, m_word, "R1 foreign write ignored");
        read_check(12'h034, 32'h0, "R1 foreign read");

        // R9: channel 0 keeps its phase when only channel 1 changes
        step(1'b1, 12'h030, 32'h0000_0071);
        for (int i = 0; i < 37; i++) step(1'b0, 12'h030, 32'h0);
        step(1'b1, 12'h030, 32'h0000_5571);
        for (int i = 0; i < 80; i++) step(1'b0, 12'h030, 32'h0);
        step(1'b1, 12'h030, 32'h9900_5571);
        for (int i = 0; i < 80; i++) step(1'b0, 12'h030, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #1_900_000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule